// File: doc/BRIEF.md
# DRAM Refresh Credit Scheduler

This block keeps count of the DRAM refreshes one memory channel still owes and asks a command scheduler to issue them. Each periodic refresh tick adds one owed refresh to a saturating counter for every rank. Each accepted refresh acknowledge pays some of that debt back. Two configuration bits choose the operating mode. With both bits clear, the block is idle. With only the accumulate bit set, it keeps counting debt but issues nothing. With refresh enabled, it runs normally.

In all-rank mode the ranks are refreshed in a fixed staggered order. The debt of every rank drops by one only when the last rank of the sequence has acknowledged. In independent-rank mode each rank pays back its own debt, and the block always points the scheduler at the rank that owes the most. A two-bit watermark code selects a debt level. Once the debt is above that level, the block flags an urgent request.

The block also arbitrates an impedance-calibration (rcomp) request against refresh traffic. In independent-rank mode the grant waits for a programmed number of refresh ticks after the latest request. The grant never coincides with a refresh request.

Top module: `refresh_credit_sched`

## Requirements
- R1: After reset all owed counts are 0, the stagger position is rank 0 and no rcomp request is pending, so ref_req, ref_urgent, panic_flag and rcomp_gnt are 0 and ref_rank is 0.
- R2: A cycle with refresh_tick high adds one owed refresh to every rank when cfg_ref_en or cfg_cnt_en is 1. With both clear, ticks leave every count unchanged.
- R3: ref_req is 1 exactly when cfg_ref_en is 1 and the largest owed count is at least 1. ref_done in a cycle where ref_req is 0 has no effect.
- R4: cfg_cnt_en has no effect while cfg_ref_en is 1.
- R5: Each owed count saturates at 15 and never falls below 0.
- R6: The watermark threshold is 5 + cfg_panic_wm (codes 0,1,2,3 give 5,6,7,8). panic_flag is 1 exactly when the largest owed count is above the threshold, and it clears once the count is at or below it. ref_urgent equals panic_flag AND cfg_ref_en.
- R7: With cfg_indep_rank = 0, ref_rank steps 0,1,...,NUM_RANKS-1 and then wraps, advancing on each accepted ref_done. Only the acknowledge of the last rank removes one owed refresh from every rank whose count is non-zero.
- R8: With cfg_indep_rank = 1, ref_rank is the rank with the largest owed count (lowest index on a tie). An accepted ref_done removes one owed refresh from that rank only. The stagger position returns to 0 while in this mode.
- R9: When an owed count is both incremented by a tick and decremented by an accepted acknowledge in the same cycle, it keeps its value.
- R10: rcomp_req makes a calibration request pending and restarts its tick count. With cfg_indep_rank = 1 the grant is allowed only once at least cfg_rcomp_wait ticks have been counted since the latest request. With cfg_indep_rank = 0 no wait applies.
- R11: rcomp_gnt is high for one cycle per grant. It is never high together with ref_req or rcomp_req, and a pending grant waits while ref_req is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| refresh_tick | input | 1 | Periodic refresh interval pulse |
| ref_done | input | 1 | Scheduler acknowledge of the requested refresh |
| rcomp_req | input | 1 | Calibration service request pulse |
| cfg_ref_en | input | 1 | Refresh issue enable |
| cfg_cnt_en | input | 1 | Keep accumulating debt while refresh is off |
| cfg_indep_rank | input | 1 | 0: staggered all-rank, 1: independent ranks |
| cfg_panic_wm | input | 2 | Urgency watermark code (threshold 5 + code) |
| cfg_rcomp_wait | input | WAIT_W (5) | Ticks to wait before rcomp grant, independent mode |
| ref_req | output | 1 | Refresh request |
| ref_urgent | output | 1 | Urgent (panic) refresh request |
| panic_flag | output | 1 | Debt above the watermark |
| ref_rank | output | RANK_W (2) | Rank the request targets |
| rcomp_gnt | output | 1 | One-cycle calibration grant |

## Verification
On every cycle the assertions check the following. Counters hold on a simultaneous tick and acknowledge, and they neither wrap at 15 nor underflow at 0. No request appears while refresh is disabled, and an urgent request always comes with a plain one. The calibration grant is a single pulse that never overlaps a refresh request. Only the bench's scenarios can show that the debt settles correctly across whole sequences: the acknowledge counts in the staggered order, the highest-debt rank selection, each watermark code, and a grant that arrives on the right tick after a restart.

// File: rtl/refresh_credit_pkg.sv
package refresh_credit_pkg;

    localparam int PANIC_BASE = 5;

    // Watermark code to debt threshold: 5 + code
    function automatic logic [4:0] wm_threshold(input logic [1:0] code);
        return 5'(PANIC_BASE) + {3'b000, code};
    endfunction

endpackage

// File: rtl/refresh_rank_counter.sv
module refresh_rank_counter #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_i,
    input  logic             dec_i,
    output logic [CNT_W-1:0] cnt_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (inc_i && dec_i) begin
            st_d.cnt = st_q.cnt;
        end else if (inc_i) begin
            if (st_q.cnt != CNT_MAX) st_d.cnt = st_q.cnt + 1'b1;
        end else if (dec_i) begin
            if (st_q.cnt != '0) st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;

    // R9: simultaneous tick and acknowledge leave the count alone
    a_r9_tick_ack_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && dec_i) |=> $stable(cnt_o));
    // R5: no wrap at the top
    a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_o == CNT_MAX && inc_i && !dec_i) |=> (cnt_o == CNT_MAX));
    // R5: no underflow at the bottom
    a_r5_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_o == '0 && !inc_i) |=> (cnt_o == '0));
    // R2: no tick and no acknowledge means a frozen count
    a_r2_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc_i && !dec_i) |=> $stable(cnt_o));

endmodule

// File: rtl/refresh_rank_select.sv
module refresh_rank_select #(
    parameter int NUM_RANKS = 4,
    parameter int CNT_W     = 4,
    parameter int RANK_W    = 2
) (
    input  logic [NUM_RANKS-1:0][CNT_W-1:0] cnt_i,
    output logic [CNT_W-1:0]                max_o,
    output logic [RANK_W-1:0]               idx_o
);
    always_comb begin
        max_o = '0;
        idx_o = '0;
        for (int r = 0; r < NUM_RANKS; r++) begin
            if (cnt_i[r] > max_o) begin
                max_o = cnt_i[r];
                idx_o = RANK_W'(r);
            end
        end
    end

endmodule

// File: rtl/rcomp_window.sv
module rcomp_window #(
    parameter int WAIT_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rcomp_req_i,
    input  logic              tick_i,
    input  logic              indep_i,
    input  logic [WAIT_W-1:0] wait_cfg_i,
    input  logic              ref_req_i,
    output logic              gnt_o
);
    localparam logic [WAIT_W-1:0] WAIT_MAX = '1;

    typedef struct packed {
        logic              pend;
        logic [WAIT_W-1:0] waited;
    } rc_state_t;

    rc_state_t st_d, st_q;
    logic      window_open;

    assign window_open = !indep_i || (st_q.waited >= wait_cfg_i);
    assign gnt_o = st_q.pend && window_open && !ref_req_i && !rcomp_req_i;

    always_comb begin
        st_d = st_q;
        if (rcomp_req_i) begin
            st_d.pend   = 1'b1;
            st_d.waited = '0;
        end else if (gnt_o) begin
            st_d.pend   = 1'b0;
            st_d.waited = '0;
        end else if (st_q.pend && tick_i && st_q.waited != WAIT_MAX) begin
            st_d.waited = st_q.waited + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R11: a grant lasts one cycle
    a_r11_gnt_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_o |=> !gnt_o);
    // R11: grant and refresh request never coincide
    a_r11_gnt_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(gnt_o && ref_req_i));
    // R10: a fresh request restarts the window before any grant
    a_r10_restart: assert property (@(posedge clk) disable iff (!rst_n)
        rcomp_req_i |=> (st_q.pend && st_q.waited == '0));

endmodule

// File: rtl/refresh_credit_sched.sv
module refresh_credit_sched #(
    parameter int NUM_RANKS = 4,
    parameter int CNT_W     = 4,
    parameter int WAIT_W    = 5,
    parameter int RANK_W    = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              refresh_tick,
    input  logic              ref_done,
    input  logic              rcomp_req,
    input  logic              cfg_ref_en,
    input  logic              cfg_cnt_en,
    input  logic              cfg_indep_rank,
    input  logic [1:0]        cfg_panic_wm,
    input  logic [WAIT_W-1:0] cfg_rcomp_wait,
    output logic              ref_req,
    output logic              ref_urgent,
    output logic              panic_flag,
    output logic [RANK_W-1:0] ref_rank,
    output logic              rcomp_gnt
);
    import refresh_credit_pkg::*;

    localparam logic [RANK_W-1:0] LAST_RANK = RANK_W'(NUM_RANKS - 1);

    typedef struct packed {
        logic [RANK_W-1:0] ptr;
    } stag_state_t;

    stag_state_t st_d, st_q;

    logic [NUM_RANKS-1:0][CNT_W-1:0] cnt;
    logic [NUM_RANKS-1:0]            dec;
    logic [CNT_W-1:0]                max_cnt;
    logic [RANK_W-1:0]               max_idx;
    logic                            accum;
    logic                            accepted;
    logic                            consume_all;
    logic [4:0]                      threshold;

    assign accum       = refresh_tick && (cfg_ref_en || cfg_cnt_en);
    assign ref_req     = cfg_ref_en && (max_cnt != '0);
    assign accepted    = ref_done && ref_req;
    assign consume_all = accepted && !cfg_indep_rank && (st_q.ptr == LAST_RANK);
    assign ref_rank    = cfg_indep_rank ? max_idx : st_q.ptr;
    assign threshold   = wm_threshold(cfg_panic_wm);
    assign panic_flag  = (5'(max_cnt) > threshold);
    assign ref_urgent  = panic_flag && cfg_ref_en;

    generate
        for (genvar r = 0; r < NUM_RANKS; r++) begin : g_rank
            assign dec[r] = cfg_indep_rank ? (accepted && max_idx == RANK_W'(r))
                                           : (consume_all && cnt[r] != '0);
            refresh_rank_counter #(.CNT_W(CNT_W)) u_cnt (
                .clk   (clk),
                .rst_n (rst_n),
                .inc_i (accum),
                .dec_i (dec[r]),
                .cnt_o (cnt[r])
            );
        end
    endgenerate

    refresh_rank_select #(
        .NUM_RANKS (NUM_RANKS),
        .CNT_W     (CNT_W),
        .RANK_W    (RANK_W)
    ) u_sel (
        .cnt_i (cnt),
        .max_o (max_cnt),
        .idx_o (max_idx)
    );

    rcomp_window #(.WAIT_W(WAIT_W)) u_rcomp (
        .clk         (clk),
        .rst_n       (rst_n),
        .rcomp_req_i (rcomp_req),
        .tick_i      (refresh_tick),
        .indep_i     (cfg_indep_rank),
        .wait_cfg_i  (cfg_rcomp_wait),
        .ref_req_i   (ref_req),
        .gnt_o       (rcomp_gnt)
    );

    always_comb begin
        st_d = st_q;
        if (cfg_indep_rank) begin
            st_d.ptr = '0;
        end else if (accepted) begin
            st_d.ptr = (st_q.ptr == LAST_RANK) ? '0 : st_q.ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R3: nothing is requested while refresh is off
    a_r3_no_req_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_ref_en |-> !ref_req);
    // R6: an urgent request is always also a request
    a_r6_urgent_is_req: assert property (@(posedge clk) disable iff (!rst_n)
        ref_urgent |-> ref_req);
    // R7: in staggered mode the rank moves only on an accepted acknowledge
    a_r7_stagger_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_indep_rank && !accepted) |=> $stable(st_q.ptr));

endmodule

// File: tb/refresh_credit_sched_tb.sv
module refresh_credit_sched_tb;
    localparam int N = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic refresh_tick = 0, ref_done = 0, rcomp_req = 0;
    logic cfg_ref_en = 0, cfg_cnt_en = 0, cfg_indep_rank = 0;
    logic [1:0] cfg_panic_wm = 0;
    logic [4:0] cfg_rcomp_wait = 5'd6;
    logic ref_req, ref_urgent, panic_flag, rcomp_gnt;
    logic [1:0] ref_rank;

    int n_tests = 0, n_fail = 0;
    int m_cnt[N];
    int m_ptr, m_wait;
    bit m_pend;
    bit s_req, s_urg, s_panic, s_gnt;
    int s_rank;

    always #10 clk = ~clk;

    refresh_credit_sched u_dut (
        .clk(clk), .rst_n(rst_n), .refresh_tick(refresh_tick), .ref_done(ref_done),
        .rcomp_req(rcomp_req), .cfg_ref_en(cfg_ref_en), .cfg_cnt_en(cfg_cnt_en),
        .cfg_indep_rank(cfg_indep_rank), .cfg_panic_wm(cfg_panic_wm),
        .cfg_rcomp_wait(cfg_rcomp_wait), .ref_req(ref_req), .ref_urgent(ref_urgent),
        .panic_flag(panic_flag), .ref_rank(ref_rank), .rcomp_gnt(rcomp_gnt)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference: highest debt, lowest index on tie
    function automatic int mx_val();
        int b = 0;
        for (int r = 0; r < N; r++) if (m_cnt[r] > b) b = m_cnt[r];
        return b;
    endfunction
    function automatic int mx_idx();
        int b = 0, ix = 0;
        for (int r = 0; r < N; r++) if (m_cnt[r] > b) begin b = m_cnt[r]; ix = r; end
        return ix;
    endfunction

    function automatic bit e_req();   return cfg_ref_en && mx_val() >= 1; endfunction
    function automatic bit e_panic(); return mx_val() > 5 + int'(cfg_panic_wm); endfunction
    function automatic int e_rank();  return cfg_indep_rank ? mx_idx() : m_ptr; endfunction
    function automatic bit e_gnt();
        return m_pend && (!cfg_indep_rank || m_wait >= int'(cfg_rcomp_wait))
               && !e_req() && !rcomp_req;
    endfunction

    task automatic model_update();
        bit acc = refresh_tick && (cfg_ref_en || cfg_cnt_en);
        bit eff = ref_done && e_req();
        bit dec[N];
        int ix = mx_idx();
        bit g = e_gnt();
        for (int r = 0; r < N; r++) dec[r] = 0;
        if (cfg_indep_rank) begin
            if (eff) dec[ix] = 1;
            m_ptr = 0;
        end else if (eff) begin
            if (m_ptr == N - 1) begin
                for (int r = 0; r < N; r++) dec[r] = (m_cnt[r] > 0);
                m_ptr = 0;
            end else m_ptr++;
        end
        for (int r = 0; r < N; r++) begin
            if (acc && dec[r]) ;
            else if (acc) m_cnt[r] = (m_cnt[r] < 15) ? m_cnt[r] + 1 : 15;
            else if (dec[r] && m_cnt[r] > 0) m_cnt[r]--;
        end
        if (rcomp_req) begin m_pend = 1; m_wait = 0; end
        else if (g) begin m_pend = 0; m_wait = 0; end
        else if (m_pend && refresh_tick && m_wait < 31) m_wait++;
    endtask

    task automatic step(input bit t, input bit a, input bit rq);
        refresh_tick = t; ref_done = a; rcomp_req = rq;
        #1;
        s_req = ref_req; s_urg = ref_urgent; s_panic = panic_flag;
        s_gnt = rcomp_gnt; s_rank = int'(ref_rank);
        check("R3 ref_req", int'(s_req), int'(e_req()));
        check("R6 panic_flag", int'(s_panic), int'(e_panic()));
        check("R6 ref_urgent", int'(s_urg), int'(e_panic() && cfg_ref_en));
        check("R8 ref_rank", s_rank, e_rank());
        check("R11 rcomp_gnt", int'(s_gnt), int'(e_gnt()));
        @(posedge clk);
        model_update();
        @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) step(1, 0, 0);
    endtask

    // Exactly n accepted acks empty the debt
    task automatic drain_check(input int n, input string tag);
        for (int i = 0; i < n - 1; i++) step(0, 1, 0);
        step(0, 1, 0);
        check(tag, int'(s_req), 1);
        step(0, 0, 0);
        check(tag, int'(s_req), 0);
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        for (int r = 0; r < N; r++) m_cnt[r] = 0;
        m_ptr = 0; m_pend = 0; m_wait = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        step(0, 0, 0);
        check("R1 req", int'(s_req), 0);
        check("R1 panic", int'(s_panic), 0);
        check("R1 gnt", int'(s_gnt), 0);
        check("R1 rank", s_rank, 0);

        // R2 both enables clear: ticks ignored
        ticks(5);
        cfg_ref_en = 1; step(0, 0, 0);
        check("R2 frozen", int'(s_req), 0);

        // R3 accumulate without issue, ack ignored
        cfg_ref_en = 0; cfg_cnt_en = 1;
        ticks(2);
        step(0, 1, 0);
        check("R3 no req when off", int'(s_req), 0);
        cfg_ref_en = 1;
        drain_check(8, "R2 R3 accumulated debt");

        // R4 cnt_en ignored with refresh on
        for (int i = 0; i < 3; i++) begin cfg_cnt_en = i[0]; step(1, 0, 0); end
        drain_check(12, "R4 cnt_en ignored");

        // R7 staggered rank order
        cfg_cnt_en = 0;
        ticks(1);
        for (int r = 0; r < N; r++) begin
            step(0, 0, 0); check("R7 rank order", s_rank, r);
            step(0, 1, 0);
        end
        step(0, 0, 0); check("R7 credit after last", int'(s_req), 0);

        // R5 saturation
        ticks(20);
        drain_check(60, "R5 saturate at 15");
        step(0, 1, 0); check("R5 no underflow", int'(s_req), 0);

        // R6 each watermark code
        for (int c = 0; c < 4; c++) begin
            cfg_panic_wm = 2'(c);
            ticks(5 + c);
            step(0, 0, 0); check("R6 at threshold", int'(s_panic), 0);
            ticks(1);
            step(0, 0, 0); check("R6 above threshold", int'(s_panic), 1);
            check("R6 urgent", int'(s_urg), 1);
            step(0, 1, 0); step(0, 1, 0); step(0, 1, 0); step(0, 1, 0);
            step(0, 0, 0); check("R6 clears", int'(s_panic), 0);
            drain_check(4 * (5 + c), "R6 drain");
        end

        // R8 independent ranks
        cfg_indep_rank = 1;
        ticks(2);
        step(0, 0, 0); check("R8 tie lowest", s_rank, 0);
        step(0, 1, 0);
        step(0, 0, 0); check("R8 highest debt", s_rank, 1);
        step(0, 1, 0);
        step(0, 0, 0); check("R8 next rank", s_rank, 2);
        for (int i = 0; i < 40 && s_req; i++) step(0, 1, 0);

        // R9 tick and ack together
        ticks(1);
        step(1, 1, 0);
        step(0, 0, 0); check("R9 hold on tick+ack", s_rank, 1);
        for (int i = 0; i < 40 && s_req; i++) step(0, 1, 0);

        // R10 independent-mode wait window with restart
        cfg_ref_en = 0; cfg_rcomp_wait = 5'd3;
        step(0, 0, 1);
        ticks(2);
        step(0, 0, 1);
        for (int i = 0; i < 3; i++) begin
            step(1, 0, 0); check("R10 wait window", int'(s_gnt), 0);
        end
        step(0, 0, 0); check("R10 grant after wait", int'(s_gnt), 1);
        step(0, 0, 0); check("R11 single pulse", int'(s_gnt), 0);

        // R10 all-rank: no wait; R11 deferral behind refresh
        cfg_indep_rank = 0; cfg_ref_en = 1;
        ticks(1);
        step(0, 0, 1);
        step(0, 0, 0); check("R11 deferred", int'(s_gnt), 0);
        for (int i = 0; i < 4; i++) step(0, 1, 0);
        step(0, 0, 0); check("R10 grant no wait", int'(s_gnt), 1);
        step(0, 0, 0); check("R11 single pulse", int'(s_gnt), 0);

        // Random mix against the model
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 63) == 0) begin
                cfg_ref_en = 1'($urandom); cfg_cnt_en = 1'($urandom);
                cfg_indep_rank = 1'($urandom); cfg_panic_wm = 2'($urandom);
                cfg_rcomp_wait = 5'($urandom_range(0, 8));
            end
            step(1'($urandom_range(0, 2) == 0), 1'($urandom_range(0, 1)),
                 1'($urandom_range(0, 30) == 0));
        end

        finish_run();
    end

endmodule